// File: doc/BRIEF.md
# SPI Board-Management Register Target

This block is a SPI target that keeps a small bank of 8-bit management registers inside a larger chip. It runs on the chip's own clock. SCLK, chip select and MOSI pass through two-flop synchronizers, and the block acts on the SCLK edges it detects from them. The SPI link uses mode 0 and sends the MSB first. MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge.

A read transaction has four bytes:
- the read opcode,
- an address byte,
- a zero filler byte,
- one byte that the target shifts out with the register contents.

A write transaction also has four bytes:
- the write opcode,
- an address byte,
- the data byte,
- a pad byte that the target ignores.

One bit of the control register at address 0x10 drives an active-high reset line to an attached storage device. A host changes that line by reading the register, changing the bit and writing the register back.

Top module: `spi_mgmt_regs`

## Requirements
- R1: A read frame is opcode 0x0B, address, one filler byte, then a fourth byte. During the fourth byte the target drives the addressed register on MISO, MSB first. Each bit is valid from the falling SCLK edge before the rising edge that samples it.
- R2: A write frame is opcode 0x02, address, data, pad. The data byte is stored into the addressed register once its eighth bit has been sampled. The pad byte changes nothing.
- R3: Any first byte other than 0x0B or 0x02 causes the rest of the frame to be ignored. No register changes, and MISO stays 0 for the whole frame.
- R4: Addresses 0x00 to 0x1F are implemented. Reading any address from 0x20 to 0xFF returns 0x00, and writes to those addresses are discarded.
- R5: Output `stor_rst` equals bit 6 of the register at address 0x10. It is 1 while that bit is set and 0 once the bit is cleared.
- R6: After reset, every register reads 0x00, `stor_rst` is 0 and MISO is 0.
- R7: While `spi_cs_n` is high, SCLK and MOSI activity has no effect and MISO is 0.
- R8: Raising `spi_cs_n` part-way through a frame aborts it. A write whose data byte is incomplete is not stored, and the next frame is decoded from its first byte.
- R9: Bytes after the fourth byte of a frame are ignored, up to a frame of 16 bytes and beyond. They cause no write, and MISO stays 0 while they are sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | Chip select for the register bank, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| stor_rst | output | 1 | Active-high reset to the storage device |

## Verification
A corrupted bit or byte counter shifts where a frame's bytes are taken. The effect shows within the same frame: the read data comes out shifted or is zero, or the write lands in the wrong place. The next read-back of that address then shows the error. A stale opcode or a missed abort shows up in the frame that follows, as a write stored by an aborted or unknown frame or as nonzero MISO on filler bytes. A wrong control bit shows at `stor_rst` a few clocks after the rising SCLK edge that completes the data byte.

// File: rtl/spi_mgmt_regs.sv
module spi_mgmt_regs #(
  parameter int NREGS     = 32,
  parameter int MAX_BYTES = 16,
  parameter logic [7:0] OP_RD   = 8'h0B,
  parameter logic [7:0] OP_WR   = 8'h02,
  parameter logic [7:0] CTL_ADR = 8'h10,
  parameter int RST_BIT   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic stor_rst
);
  localparam int AW  = $clog2(NREGS);
  localparam int BCW = $clog2(MAX_BYTES + 1);
  localparam logic [BCW-1:0] BLIM = BCW'(MAX_BYTES);

  logic [2:0] sclk_p;
  logic [1:0] cs_p, mosi_p;
  logic       rise, fall, cs_act;
  logic [2:0] bit_cnt;
  logic [BCW-1:0] byte_cnt;
  logic [7:0] shin, sh, opcode, addr, outsh;
  logic       miso_r;
  logic [7:0] regs [NREGS];
  logic [7:0] rd_byte;

  assign rise   = sclk_p[1] & ~sclk_p[2];
  assign fall   = ~sclk_p[1] & sclk_p[2];
  assign cs_act = ~cs_p[1];
  assign sh     = {shin[6:0], mosi_p[1]};
  assign rd_byte  = (int'(sh) < NREGS) ? regs[sh[AW-1:0]] : 8'h00;
  assign spi_miso = miso_r;
  assign stor_rst = regs[CTL_ADR[AW-1:0]][RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], spi_sclk};
      cs_p   <= {cs_p[0], spi_cs_n};
      mosi_p <= {mosi_p[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shin     <= '0;
      opcode   <= '0;
      addr     <= '0;
      outsh    <= '0;
      miso_r   <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (!cs_act) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      opcode   <= '0;
      miso_r   <= 1'b0;
    end else begin
      if (rise) begin
        shin    <= sh;
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt != BLIM) byte_cnt <= byte_cnt + 1'b1;
          case (byte_cnt)
            BCW'(0): opcode <= sh;
            BCW'(1): begin
              addr  <= sh;
              outsh <= rd_byte;
            end
            BCW'(2): if (opcode == OP_WR && int'(addr) < NREGS)
                       regs[addr[AW-1:0]] <= sh;
            default: ;
          endcase
        end
      end
      if (fall) begin
        if (byte_cnt == BCW'(3) && opcode == OP_RD) begin
          miso_r <= outsh[7];
          outsh  <= {outsh[6:0], 1'b0};
        end else begin
          miso_r <= 1'b0;
        end
      end
    end
  end

  assert_miso_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso);
  assert_miso_only_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso |-> (opcode == OP_RD));
  assert_rst_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && cs_act) |=> $stable(stor_rst));
  assert_byte_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= BLIM);
  assert_reset_clear_R6: assert property (@(posedge clk)
    !rst_n |=> (!stor_rst && !spi_miso));
endmodule

// File: tb/tb_spi_mgmt_regs.sv
module tb_spi_mgmt_regs;
  localparam int H = 5;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, srst;
  int total = 0, bad = 0;
  logic [7:0] expv [256];

  spi_mgmt_regs dut (.clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
                     .spi_mosi(mosi), .spi_miso(miso), .stor_rst(srst));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      wait_clk(H);
      rx[i] = miso;
      sclk = 1;
      wait_clk(H);
      sclk = 0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    bits(tx, 8, rx);
  endtask

  task automatic cs_on;  cs_n = 0; wait_clk(H); endtask
  task automatic cs_off; wait_clk(H); cs_n = 1; wait_clk(2*H); endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r;
    cs_on(); xbyte(8'h02, r); xbyte(a, r); xbyte(d, r); xbyte(8'h00, r); cs_off();
    if (a < 8'h20) expv[a] = d;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    logic [7:0] r;
    cs_on(); xbyte(8'h0B, r); xbyte(a, r); xbyte(8'h00, r); xbyte(8'h00, d); cs_off();
  endtask

  initial begin
    wait_clk(200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, r;
    for (int i = 0; i < 256; i++) expv[i] = 8'h00;
    wait_clk(4); rst_n = 1; wait_clk(4);
    chk("R6 stor_rst", {7'b0, srst}, 8'h00);
    chk("R6 miso", {7'b0, miso}, 8'h00);
    rd(8'h10, d); chk("R6 ctrl reset value", d, 8'h00);
    rd(8'h1F, d); chk("R6 top reg reset value", d, 8'h00);

    // R2 R4: write sweep over implemented and some unimplemented addresses
    for (int a = 0; a < 48; a++) wr(8'(a), 8'((a * 37 + 5) & 8'hBF));
    wr(8'h80, 8'h5A); wr(8'hFF, 8'hA5); wr(8'h3C, 8'h77); wr(8'hC0, 8'h11);
    // R1 R4: read sweep of the whole address space
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), d);
      chk(a < 32 ? "R1 read implemented" : "R4 read unimplemented", d, expv[a]);
    end
    chk("R5 bit6 clear after sweep", {7'b0, srst}, {7'b0, expv[16][6]});

    // R5: read-modify-write of the control bit
    rd(8'h10, d); wr(8'h10, d | 8'h40); wait_clk(4);
    chk("R5 reset asserted", {7'b0, srst}, 8'h01);
    rd(8'h10, d); chk("R5 ctrl readback", d, expv[16]);
    wr(8'h10, d & 8'hBF); wait_clk(4);
    chk("R5 reset released", {7'b0, srst}, 8'h00);

    // R3: unknown opcode, write-like body, MISO must stay zero
    cs_on();
    xbyte(8'h03, r); chk("R3 miso b0", r, 8'h00);
    xbyte(8'h05, r); chk("R3 miso b1", r, 8'h00);
    xbyte(8'hEE, r); chk("R3 miso b2", r, 8'h00);
    xbyte(8'h00, r); chk("R3 miso b3", r, 8'h00);
    cs_off();
    rd(8'h05, d); chk("R3 no write", d, expv[5]);

    // R7: activity with chip select high
    mosi = 1;
    for (int i = 0; i < 32; i++) begin
      sclk = 1; wait_clk(H); sclk = 0; wait_clk(H);
    end
    chk("R7 miso idle", {7'b0, miso}, 8'h00);
    rd(8'h07, d); chk("R7 no effect", d, expv[7]);

    // R8: abort during data byte, then fresh frame
    cs_on(); xbyte(8'h02, r); xbyte(8'h07, r); bits(8'hFF, 5, r); cs_off();
    rd(8'h07, d); chk("R8 aborted write dropped", d, expv[7]);
    cs_on(); xbyte(8'h0B, r); bits(8'h00, 3, r); cs_off();
    wr(8'h07, 8'h3D);
    rd(8'h07, d); chk("R8 fresh decode after abort", d, 8'h3D);

    // R9: long frames
    cs_on(); xbyte(8'h02, r); xbyte(8'h09, r); xbyte(8'h66, r); xbyte(8'h00, r);
    for (int i = 0; i < 14; i++) xbyte(8'h02, r);
    cs_off(); expv[9] = 8'h66;
    rd(8'h02, d); chk("R9 trailing bytes no write", d, expv[2]);
    rd(8'h09, d); chk("R9 write in long frame", d, 8'h66);
    cs_on(); xbyte(8'h0B, r); xbyte(8'h09, r); xbyte(8'h00, r); xbyte(8'h00, d);
    chk("R9 read data in long frame", d, 8'h66);
    for (int i = 4; i < 18; i++) begin
      xbyte(8'hFF, r); chk("R9 miso after data", r, 8'h00);
    end
    cs_off();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule